// File: doc/BRIEF.md
# Character Display Video Address Counter

This block produces the video memory pointer for a character-based display controller. A 14-bit character address counts up once per character clock while the display window is open. A second 14-bit register keeps the address at which the current character row began. At each raster line start the counter is reloaded, either from that saved row address or from the programmed start address. The source depends on a reload variant chosen while the block is held in reset.

The start address is written one byte at a time through a small register-write port. An external timing generator supplies the line-start, frame-start and row-end strobes, the character clock enable, the display enable, the vertical character count and the raster address. The block turns the counter into a 16-bit byte address for video RAM. Counter bits 11:10 never reach that address. They matter only for carries: when both are set, counting past the end of a 1024-character buffer ripples into the page bits, which gives a 32KB screen. With any other value of those two bits, the visible address wraps inside its 16KB page.

Top module: `crtc_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `ma`, the saved row address and the start address are all zero.
- R2: A write with `wr_sel`=0 sets start-address bits 13:8 from `wr_data[5:0]`, and `wr_data[7:6]` are ignored. A write with `wr_sel`=1 sets start-address bits 7:0. Reloads in the same cycle use the value from before the write.
- R3: When `line_start` is low and both `char_en` and `disp_en` are high, `ma` increases by one, modulo 2^14. In every other cycle without `line_start`, `ma` holds.
- R4: The counter carries through all 14 bits. Counting from 0x0FFF moves `vaddr[15:14]` from 00 to 01. Counting from 0x07FF leaves `vaddr[15:14]` at 00 and returns the offset to 0.
- R5: `vaddr` = {`ma[13:12]`, `ra[2:0]`, `ma[9:0]`, `clk_phase`}.
- R6: Mode 0 or 3: on `line_start` with `frame_start`, both `ma` and the saved row address are loaded from the start address.
- R7: Mode 0 or 3: on `line_start` without `frame_start`, `ma` is loaded from the saved row address.
- R8: Mode 1: on every `line_start` with `vcc`=0, `ma` is loaded from the start address. On a `line_start` with `vcc`≠0, `ma` is loaded from the saved row address. In this mode `frame_start` never changes the saved row address.
- R9: Mode 2: on every `line_start`, `ma` is loaded from the saved row address, including the one that carries `frame_start`. With `frame_start`, the saved row address takes the start address in the same cycle.
- R10: A `save_row` pulse copies the current `ma` into the saved row address, unless a frame load of the saved row address (R6, R9) happens in the same cycle.
- R11: `reload_mode` is captured only while `rst_n` is low. Changes after reset have no effect.
- R12: A start-address write made while `vcc`≠0 reaches `ma` only at the next frame-start line (modes 0 and 3), or at the next line start with `vcc`=0 (mode 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reload_mode | input | 2 | Reload variant, sampled in reset: 0/3 frame-start, 1 first-row, 2 saved-only |
| wr_en | input | 1 | Start-address byte write strobe |
| wr_sel | input | 1 | 0 = upper start byte, 1 = lower start byte |
| wr_data | input | 8 | Write data |
| line_start | input | 1 | Raster line start strobe |
| frame_start | input | 1 | Qualifies `line_start` as the first line of the frame |
| save_row | input | 1 | Row-end strobe: capture `ma` as the next row's start |
| char_en | input | 1 | Character clock enable |
| disp_en | input | 1 | Display window open |
| vcc | input | VCC_W | Vertical character row count |
| ra | input | 3 | Raster address within the row |
| clk_phase | input | 1 | Byte select within a character |
| ma | output | 14 | Character address counter |
| vaddr | output | 16 | Video RAM byte address |

## Verification
The bench targets three corner cases. The first is the carry out of the 1024-character offset with bits 11:10 both set and with only one of them set. A design that hid the carry, or let it leak into the page, would show the wrong page on `vaddr`. The second is a line start that reloads in the same cycle as a start-address write or a row save. A design that gave the wrong source priority would pick up the new start address too early, or lose the saved row address. The third set of corner cases is specific to each mode. In mode 1, lines with `vcc`=0 must reload from the start address while later rows reload from the saved row address. In mode 2, the first line must show the old saved row address. After reset, `reload_mode` is toggled, and a block that kept sampling it would change its reload pattern in the middle of a run.

// File: rtl/crtc_addr_gen.sv
module crtc_addr_gen #(
  parameter int VCC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reload_mode,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             line_start,
  input  logic             frame_start,
  input  logic             save_row,
  input  logic             char_en,
  input  logic             disp_en,
  input  logic [VCC_W-1:0] vcc,
  input  logic [2:0]       ra,
  input  logic             clk_phase,
  output logic [13:0]      ma,
  output logic [15:0]      vaddr
);

  logic [1:0]  mode_q;
  logic [13:0] start_q, ma_q, save_q;

  wire first_row_mode = (mode_q == 2'd1);
  wire saved_mode     = (mode_q == 2'd2);
  wire frame_ld       = line_start && frame_start && !first_row_mode;
  wire count          = char_en && disp_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= reload_mode;
      start_q <= '0;
      ma_q    <= '0;
      save_q  <= '0;
    end else begin
      if (wr_en) begin
        if (wr_sel) start_q[7:0]  <= wr_data;
        else        start_q[13:8] <= wr_data[5:0];
      end
      if (line_start) begin
        if (first_row_mode)                    ma_q <= (vcc == '0) ? start_q : save_q;
        else if (saved_mode || !frame_start)   ma_q <= save_q;
        else                                   ma_q <= start_q;
      end else if (count) begin
        ma_q <= ma_q + 14'd1;
      end
      if (frame_ld)      save_q <= start_q;
      else if (save_row) save_q <= ma_q;
    end
  end

  assign ma    = ma_q;
  assign vaddr = {ma_q[13:12], ra, ma_q[9:0], clk_phase};

  assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!line_start && count) |-> ma_q == $past(ma_q) + 14'd1);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!line_start && !count) |-> $stable(ma_q));

  assert_frame_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(line_start && frame_start) && (mode_q == 2'd0 || mode_q == 2'd3)
      |-> ma_q == $past(start_q) && save_q == $past(start_q));

  assert_saved_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(line_start) && saved_mode |-> ma_q == $past(save_q));

  assert_mode_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));

endmodule

// File: tb/tb_crtc_addr_gen.sv
module tb_crtc_addr_gen;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] reload_mode = 0;
  logic wr_en = 0, wr_sel = 0, line_start = 0, frame_start = 0, save_row = 0;
  logic char_en = 0, disp_en = 0, clk_phase = 0;
  logic [7:0] wr_data = 0;
  logic [6:0] vcc = 0;
  logic [2:0] ra = 0;
  logic [13:0] ma;
  logic [15:0] vaddr;

  crtc_addr_gen dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [13:0] ma_m, save_m, start_m;
  logic [1:0] mode_m;

  function automatic logic [15:0] exp_vaddr(logic [13:0] a, logic [2:0] r, logic p);
    return {a[13:12], r, a[9:0], p};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic ls, logic fs, logic ce, logic de, logic sr,
                      logic we, logic ws, logic [7:0] wd, logic [6:0] v, string tag);
    logic [13:0] nma, nsv, nst;
    line_start = ls; frame_start = fs; char_en = ce; disp_en = de; save_row = sr;
    wr_en = we; wr_sel = ws; wr_data = wd; vcc = v;
    ra = 3'($urandom); clk_phase = 1'($urandom);
    nma = ma_m; nsv = save_m; nst = start_m;
    if (we) begin
      if (ws) nst[7:0] = wd; else nst[13:8] = wd[5:0];
    end
    if (ls) begin
      case (mode_m)
        2'd1: nma = (v == 0) ? start_m : save_m;
        2'd2: nma = save_m;
        default: nma = fs ? start_m : save_m;
      endcase
    end else if (ce && de) nma = ma_m + 14'd1;
    if (ls && fs && mode_m != 2'd1) nsv = start_m;
    else if (sr) nsv = ma_m;
    @(posedge clk);
    ma_m = nma; save_m = nsv; start_m = nst;
    @(negedge clk);
    check({tag, " R5"}, vaddr, exp_vaddr(ma_m, ra, clk_phase));
    check(tag, {2'b0, ma}, {2'b0, ma_m});
  endtask

  task automatic do_reset(logic [1:0] m);
    @(negedge clk);
    rst_n = 0; reload_mode = m;
    line_start = 0; char_en = 0; disp_en = 0; wr_en = 0; save_row = 0;
    repeat (3) @(negedge clk);
    check("R1", {2'b0, ma}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1", vaddr, exp_vaddr(14'h0, ra, clk_phase));
    reload_mode = ~m;
    ma_m = 0; save_m = 0; start_m = 0; mode_m = m;
  endtask

  task automatic write_start(logic [13:0] s);
    step(0, 0, 0, 0, 0, 1, 0, {2'b11, s[13:8]}, 1, "R2");
    step(0, 0, 0, 0, 0, 1, 1, s[7:0], 1, "R2");
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset(2'd0);
    write_start(14'h0FFE);
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 1, 1, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 1, 0, 0, 0, 0, 0, "R4");
    check("R4", {14'h0, vaddr[15:14]}, 16'h1);
    write_start(14'h07FF);
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 1, 1, 0, 0, 0, 0, 0, "R4");
    check("R4", {vaddr[15:14], 4'h0, vaddr[10:1]}, 16'h0);
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 0, 0, 0, 0, 0, 2, "R7");
    write_start(14'h2345);
    step(1, 0, 0, 0, 0, 0, 0, 0, 3, "R12");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R12");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R10");

    for (int mode = 0; mode < 4; mode++) begin
      do_reset(2'(mode));
      for (int i = 0; i < 1500; i++) begin
        logic ls, fs, we, sr;
        string tag;
        ls = ($urandom % 8) == 0;
        fs = ls && (($urandom % 4) == 0);
        we = ($urandom % 8) == 0;
        sr = ($urandom % 16) == 0;
        if (ls) tag = (mode == 1) ? "R8" : (mode == 2) ? "R9" : fs ? "R6" : "R7";
        else if (we) tag = "R2";
        else if (sr) tag = "R10";
        else tag = "R3";
        if (i % 97 == 0) reload_mode = 2'($urandom);
        step(ls, fs, ($urandom % 4) != 0, ($urandom % 4) != 0, sr, we,
             1'($urandom), 8'($urandom), 7'($urandom % 4), {tag, " R11 R12"});
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule